// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

An eight-pin general-purpose I/O port. Each pin can be an input or an output, and each pin can be lent to an on-chip peripheral. When a pin is lent out, the peripheral's own value and output enable reach the pad in place of the port's registers. Every pin also has an interrupt flag. The flag is set by a level transition whose polarity is chosen per pin. A constant level never sets it. A per-pin enable gates the flags onto one combined interrupt request.

Software reaches the port through a small register bus. The bus has a 3-bit address, a write strobe, write data and read data. Read data is combinational from the address. Pad inputs pass through a two-flop synchronizer, and the synchronized level feeds both the input register and the edge detector.

A small warm-up state machine guards the edge detector after reset. The machine starts in WARM0 at reset. It steps unconditionally WARM0 -> WARM1 -> WARM2 -> LIVE on successive clocks and then stays in LIVE. Edges are detected only in LIVE. By then the synchronizer and the history flop hold real pad samples, so a pin held high through reset is not mistaken for a rising edge. A transition that occurs during the warm-up cycles is not flagged.

Register map (3-bit address):

| Address | Register | Access |
|---|---|---|
| 0 | input level | read-only |
| 1 | output value | read/write |
| 2 | direction | read/write |
| 3 | function select | read/write |
| 4 | interrupt flags | read/write |
| 5 | edge select | read/write |
| 6 | interrupt enable | read/write |
| 7 | reserved | reads 0 |

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, all registers at addresses 1 to 6 read 0. `pad_oe` is 0, `pad_out` is 0 and `irq` is 0.
- R2: A read of address 0 returns the pad level two clock edges after the pad changes. A write to address 0 has no effect.
- R3: For a pin whose function-select bit is 0, `pad_oe` equals its direction bit (1 = output, 0 = input) and `pad_out` equals its output-register bit.
- R4: For a pin whose function-select bit is 1, `pad_out` equals `alt_out` and `pad_oe` equals `alt_oe` for that pin.
- R5: With edge-select bit 0, a low-to-high transition sets the pin's flag; with edge-select bit 1, a high-to-low transition sets it. The flag is first read as 1 after the third rising clock edge that follows the pad change, and not after the second.
- R6: A transition of the other polarity, or a pin held at a constant level, never sets a flag.
- R7: A write to address 4 replaces the flag bits with the write data. If a hardware edge and a write of 0 hit the same bit on the same clock edge, the bit ends up 1.
- R8: `irq` is 1 exactly when some bit is 1 in both the flag register and the enable register (address 6).
- R9: Reads of address 7 return 0, and writes to address 7 change no register.
- R10: The warm-up machine passes WARM0, WARM1 and WARM2 before LIVE and then stays in LIVE. A pin held high from reset onward does not set its flag, even with edge-select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Value driven toward the pads |
| pad_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Peripheral output value per pin |
| alt_oe | input | 8 | Peripheral output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The three kinds of result fall due at different times.
- Pad outputs and read data follow the registers combinationally, so they are due right after the clock edge that takes a write.
- The input register shows a pad change after two rising edges.
- A flag, and `irq` behind it, appears after the third rising edge.

The bench drives every stimulus on a falling edge and counts the falling edges that follow. It reads the flag register after the second edge, where it must still be 0, and again after the third, where it must be set. The hardware-versus-software race is staged by placing the write strobe across exactly that third edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] A_LEVEL = 3'd0;
    localparam logic [REG_AW-1:0] A_OUT   = 3'd1;
    localparam logic [REG_AW-1:0] A_DIR   = 3'd2;
    localparam logic [REG_AW-1:0] A_FSEL  = 3'd3;
    localparam logic [REG_AW-1:0] A_FLAG  = 3'd4;
    localparam logic [REG_AW-1:0] A_ESEL  = 3'd5;
    localparam logic [REG_AW-1:0] A_IEN   = 3'd6;

    typedef enum logic [1:0] {
        WARM0 = 2'd0,
        WARM1 = 2'd1,
        WARM2 = 2'd2,
        LIVE  = 2'd3
    } warm_state_e;

endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] esel,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] hw_set
);

    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] lvl_q;
    logic [NPINS-1:0] hist_q;
    warm_state_e      state_q;
    warm_state_e      state_d;
    logic             detect_en;

    // synchronizer and history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_q  <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= pad_in;
            lvl_q  <= meta_q;
            hist_q <= lvl_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WARM0;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        detect_en = 1'b0;
        unique case (state_q)
            WARM0: state_d = WARM1;
            WARM1: state_d = WARM2;
            WARM2: state_d = LIVE;
            LIVE: begin
                state_d   = LIVE;
                detect_en = 1'b1;
            end
        endcase
    end

    logic [NPINS-1:0] rise;
    logic [NPINS-1:0] fall;
    assign rise   = lvl_q & ~hist_q;
    assign fall   = ~lvl_q & hist_q;
    assign hw_set = detect_en ? ((rise & ~esel) | (fall & esel)) : '0;
    assign level  = lvl_q;

    // R5 R6
    edge_is_transition_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set & ~(lvl_q ^ $past(lvl_q))) == '0));

    // R10
    live_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LIVE) |=> (state_q == LIVE));

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] addr,
    input  logic              wr,
    input  logic [NPINS-1:0]  wdata,
    input  logic [NPINS-1:0]  level,
    input  logic [NPINS-1:0]  hw_set,
    output logic [NPINS-1:0]  rdata,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  fsel_q,
    output logic [NPINS-1:0]  flag_q,
    output logic [NPINS-1:0]  esel_q,
    output logic [NPINS-1:0]  ien_q
);

    logic wr_out, wr_dir, wr_fsel, wr_flag, wr_esel, wr_ien;
    assign wr_out  = wr && (addr == A_OUT);
    assign wr_dir  = wr && (addr == A_DIR);
    assign wr_fsel = wr && (addr == A_FSEL);
    assign wr_flag = wr && (addr == A_FLAG);
    assign wr_esel = wr && (addr == A_ESEL);
    assign wr_ien  = wr && (addr == A_IEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            fsel_q <= '0;
            esel_q <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_out)  out_q  <= wdata;
            if (wr_dir)  dir_q  <= wdata;
            if (wr_fsel) fsel_q <= wdata;
            if (wr_esel) esel_q <= wdata;
            if (wr_ien)  ien_q  <= wdata;
        end
    end

    // hardware edge wins over a software clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (wr_flag ? wdata : flag_q) | hw_set;
    end

    always_comb begin
        case (addr)
            A_LEVEL: rdata = level;
            A_OUT:   rdata = out_q;
            A_DIR:   rdata = dir_q;
            A_FSEL:  rdata = fsel_q;
            A_FLAG:  rdata = flag_q;
            A_ESEL:  rdata = esel_q;
            A_IEN:   rdata = ien_q;
            default: rdata = '0;
        endcase
    end

    // R5 R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_set) |=> ((flag_q & $past(hw_set)) == $past(hw_set)));

    // R6
    flag_no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_flag |=> ((flag_q & ~$past(flag_q) & ~$past(hw_set)) == '0));

    // R9
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_out |=> $stable(out_q));

endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int NPINS = 8
) (
    input  logic [NPINS-1:0] fsel,
    input  logic [NPINS-1:0] out_val,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] alt_out,
    input  logic [NPINS-1:0] alt_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        assign pad_out[p] = fsel[p] ? alt_out[p] : out_val[p];
        assign pad_oe[p]  = fsel[p] ? alt_oe[p]  : dir[p];
    end

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    output logic              irq
);

    logic [NPINS-1:0] level, hw_set;
    logic [NPINS-1:0] out_q, dir_q, fsel_q, flag_q, esel_q, ien_q;

    gpio_edge_detect #(.NPINS(NPINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .esel   (esel_q),
        .level  (level),
        .hw_set (hw_set)
    );

    gpio_regfile #(.NPINS(NPINS)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (bus_addr),
        .wr     (bus_wr),
        .wdata  (bus_wdata),
        .level  (level),
        .hw_set (hw_set),
        .rdata  (bus_rdata),
        .out_q  (out_q),
        .dir_q  (dir_q),
        .fsel_q (fsel_q),
        .flag_q (flag_q),
        .esel_q (esel_q),
        .ien_q  (ien_q)
    );

    gpio_pin_mux #(.NPINS(NPINS)) u_mux (
        .fsel    (fsel_q),
        .out_val (out_q),
        .dir     (dir_q),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign irq = |(flag_q & ien_q);

endmodule

// File: tb/gpio_edge_port_tb.sv
module gpio_edge_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe;
    logic [7:0] alt_out = '0, alt_oe = '0;
    logic       irq;

    int nchk = 0;
    int nerr = 0;

    always #5 clk = ~clk;

    gpio_edge_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out),
        .alt_oe(alt_oe), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp;
        logic [7:0] bases [2];
        logic [7:0] esels [4];
        bases[0] = 8'h00; bases[1] = 8'hFF;
        esels[0] = 8'h00; esels[1] = 8'hFF; esels[2] = 8'hA5; esels[3] = 8'h3C;

        @(negedge clk);
        do_reset();

        // R1 reset state
        for (int a = 1; a <= 6; a++) begin
            rd_reg(3'(a), v);
            chk(v, 8'h00, $sformatf("R1 reg %0d after reset", a));
        end
        chk(pad_oe, 8'h00, "R1 pad_oe after reset");
        chk(pad_out, 8'h00, "R1 pad_out after reset");
        chk({7'd0, irq}, 8'h00, "R1 irq after reset");

        // R10 pin held high through reset must not flag
        pad_in = 8'hFF;
        do_reset();
        repeat (10) @(negedge clk);
        rd_reg(3'd4, v);
        chk(v, 8'h00, "R10 high-through-reset no flag");
        rd_reg(3'd0, v);
        chk(v, 8'hFF, "R2 level after warm-up");

        // R2 write to input register ignored
        wr_reg(3'd0, 8'h00);
        rd_reg(3'd0, v);
        chk(v, 8'hFF, "R2 write to level ignored");

        // R3 direction/output sweep
        for (int d = 0; d < 256; d++) begin
            wr_reg(3'd2, 8'(d));
            wr_reg(3'd1, 8'(d * 37 + 11));
            chk(pad_oe, 8'(d), "R3 pad_oe follows dir");
            chk(pad_out, 8'(d * 37 + 11), "R3 pad_out follows out");
        end

        // R4 function select sweep
        wr_reg(3'd2, 8'h0F);
        wr_reg(3'd1, 8'h55);
        alt_out = 8'hC3;
        alt_oe  = 8'hF0;
        for (int f = 0; f < 256; f++) begin
            logic [7:0] fs;
            fs = 8'(f);
            wr_reg(3'd3, fs);
            chk(pad_out, (fs & 8'hC3) | (~fs & 8'h55), "R4 pad_out mux");
            chk(pad_oe, (fs & 8'hF0) | (~fs & 8'h0F), "R4 pad_oe mux");
        end
        wr_reg(3'd3, 8'h00);

        // R5 R6 R8 edge sweep
        wr_reg(3'd6, 8'hFF);
        foreach (bases[b]) begin
            foreach (esels[e]) begin
                pad_in = bases[b];
                wr_reg(3'd5, esels[e]);
                repeat (4) @(negedge clk);
                wr_reg(3'd4, 8'h00);
                for (int i = 0; i < 8; i++) begin
                    logic rising, match;
                    rising = ~bases[b][i];
                    match  = rising ? ~esels[e][i] : esels[e][i];
                    exp    = match ? 8'(1 << i) : 8'h00;
                    pad_in = bases[b] ^ 8'(1 << i);
                    repeat (2) @(negedge clk);
                    rd_reg(3'd4, v);
                    chk(v, 8'h00, "R5 flag not before third edge");
                    rd_reg(3'd0, v);
                    chk(v, pad_in, "R2 level after two edges");
                    @(negedge clk);
                    rd_reg(3'd4, v);
                    chk(v, exp, $sformatf("R5 R6 flag pin %0d", i));
                    chk({7'd0, irq}, {7'd0, match}, "R8 irq from edge");
                    pad_in = bases[b];
                    repeat (4) @(negedge clk);
                    wr_reg(3'd4, 8'h00);
                end
            end
        end

        // R6 static level never flags
        wr_reg(3'd4, 8'h00);
        pad_in = 8'h5A;
        repeat (5) @(negedge clk);
        wr_reg(3'd4, 8'h00);
        repeat (20) @(negedge clk);
        rd_reg(3'd4, v);
        chk(v, 8'h00, "R6 static level");

        // R7 software set and R8 irq sweep
        wr_reg(3'd4, 8'h96);
        rd_reg(3'd4, v);
        chk(v, 8'h96, "R7 software write flags");
        for (int en = 0; en < 256; en++) begin
            wr_reg(3'd6, 8'(en));
            chk({7'd0, irq}, {7'd0, |(8'h96 & 8'(en))}, "R8 irq gating");
        end

        // R7 hardware set wins over same-cycle clear
        wr_reg(3'd5, 8'h00);
        pad_in = 8'h00;
        repeat (4) @(negedge clk);
        wr_reg(3'd4, 8'h01);
        pad_in = 8'h80;
        repeat (2) @(negedge clk);
        wr_reg(3'd4, 8'h00);
        rd_reg(3'd4, v);
        chk(v, 8'h80, "R7 hardware set wins");

        // R9 reserved address
        wr_reg(3'd1, 8'h12);
        wr_reg(3'd2, 8'h34);
        wr_reg(3'd3, 8'h00);
        wr_reg(3'd5, 8'h78);
        wr_reg(3'd6, 8'h9A);
        wr_reg(3'd4, 8'h00);
        wr_reg(3'd7, 8'hFF);
        rd_reg(3'd7, v); chk(v, 8'h00, "R9 reserved reads 0");
        rd_reg(3'd1, v); chk(v, 8'h12, "R9 out unchanged");
        rd_reg(3'd2, v); chk(v, 8'h34, "R9 dir unchanged");
        rd_reg(3'd3, v); chk(v, 8'h00, "R9 fsel unchanged");
        rd_reg(3'd4, v); chk(v, 8'h00, "R9 flag unchanged");
        rd_reg(3'd5, v); chk(v, 8'h78, "R9 esel unchanged");
        rd_reg(3'd6, v); chk(v, 8'h9A, "R9 ien unchanged");

        $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule